// File: doc/BRIEF.md
# Freezable Cross-Domain Register Shadow

This block carries configuration writes from a fast bus clock domain into a slow counter clock domain. Three registers are mirrored: a control word and two compare words. A bus write lands in a fast-domain shadow copy. A single toggle request/acknowledge channel then moves a snapshot of the shadows into slow-domain copies. Each register has its own busy flag, so software can tell that its value has not yet reached the slow side.

A freeze control lets software batch updates. While freeze is on, written values stay in the shadows and nothing is launched. When freeze is turned off, every register written during the freeze is sent in one transfer. The slow-domain copies of all those registers then change on the same slow clock edge.

A write to a register whose transfer is still in flight is accepted into the shadow. That newer value is launched as soon as the current transfer has been acknowledged.

Top module: `cdc_reg_shadow`

## Requirements
- R1: After both resets, `busy` is 0 and all three slow-domain outputs are 0.
- R2: With freeze off, a write with `wrSel` 0 (control), 1 (compare 0) or 2 (compare 1) sets that register's `busy` bit on the first bus clock edge after the write. The written value later appears on the matching slow output. The busy bit returns to 0 only once that value is visible.
- R3: A write affects only the busy bit and the slow output of the selected register. The other registers' outputs keep their values.
- R4: A write with `wrSel` 3 sets the freeze state to `wrData[0]`. While freeze is on and no transfer is in flight, `busy` stays 0, the slow outputs do not change, and register writes are held in the shadows. A freeze write does not alter any register value.
- R5: Clearing freeze raises, on the next bus clock, the busy bits of every register written during the freeze. Their new values all appear on the slow outputs at the same slow clock edge.
- R6: A write to a register that is busy is accepted. The busy bit stays high until the last written value is visible on the slow output. While a transfer is in flight, the snapshot being carried does not change.
- R7: Slow-domain outputs change only on the slow clock edge that also toggles the acknowledge sent back to the bus domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Fast bus clock |
| busRstN | input | 1 | Active-low reset, bus domain |
| slowClk | input | 1 | Slow counter clock |
| slowRstN | input | 1 | Active-low reset, slow domain |
| wrEn | input | 1 | Write strobe, one bus cycle per write |
| wrSel | input | 2 | Target: 0 control, 1 compare 0, 2 compare 1, 3 freeze |
| wrData | input | DATA_W | Write value (bit 0 is the freeze value) |
| busy | output | 3 | Per-register transfer-in-progress flags, bit index = `wrSel` |
| slowCtrl | output | DATA_W | Slow-domain control copy |
| slowCmp0 | output | DATA_W | Slow-domain compare 0 copy |
| slowCmp1 | output | DATA_W | Slow-domain compare 1 copy |

## Verification
The hardest case to reach is a register rewritten while its own transfer is still crossing. Here the first value must land, the second must be relaunched, and busy must never drop in between. The bench issues two writes to one register on back-to-back bus cycles. It then samples busy on every bus cycle until the second value shows on the slow output. The freeze batch is a second hard case. For every non-empty subset of the three registers, the bench holds the writes under freeze and then releases them. It watches each slow clock edge for a partial update, in which some but not all of the batched registers hold their new values.

// File: rtl/cdc_reg_shadow_pkg.sv
package cdc_reg_shadow_pkg;
  localparam int NUM_REGS = 3;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_FREEZE = 2'd3;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrStrobe;
    logic                launch;
    logic [NUM_REGS-1:0] launchMask;
  } strobe_t;
endpackage

// File: rtl/cdc_reg_shadow_ctrl.sv
module cdc_reg_shadow_ctrl
  import cdc_reg_shadow_pkg::*;
(
  input  logic                busClk,
  input  logic                busRstN,
  input  logic                wrEn,
  input  logic [SEL_W-1:0]    wrSel,
  input  logic                wrBit0,
  input  logic                ackTogIn,
  output strobe_t             strobes,
  output logic [NUM_REGS-1:0] busy,
  output logic                inFlight,
  output logic                freezeOn
);
  logic [NUM_REGS-1:0] pending;
  logic [NUM_REGS-1:0] flightMask;
  logic [NUM_REGS-1:0] wrMask;
  logic [1:0]          ackSync;
  logic                reqTog;
  logic                freezeWr;
  logic                launch;

  always_comb begin
    wrMask = '0;
    if (wrEn && (wrSel != SEL_FREEZE)) wrMask[wrSel] = 1'b1;
  end

  assign freezeWr = wrEn && (wrSel == SEL_FREEZE);
  assign inFlight = reqTog ^ ackSync[1];
  assign launch   = !inFlight && !freezeOn && (pending != '0);

  assign strobes.wrStrobe   = wrMask;
  assign strobes.launch     = launch;
  assign strobes.launchMask = pending;

  assign busy = (inFlight ? flightMask : '0) | (freezeOn ? '0 : pending);

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      pending    <= '0;
      flightMask <= '0;
      ackSync    <= '0;
      reqTog     <= 1'b0;
      freezeOn   <= 1'b0;
    end else begin
      ackSync <= {ackSync[0], ackTogIn};
      if (freezeWr) freezeOn <= wrBit0;
      pending <= (pending & ~(launch ? pending : '0)) | wrMask;
      if (launch) begin
        reqTog     <= ~reqTog;
        flightMask <= pending;
      end
    end
  end
endmodule

// File: rtl/cdc_reg_shadow_data.sv
module cdc_reg_shadow_data
  import cdc_reg_shadow_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                           busClk,
  input  logic                           busRstN,
  input  logic                           slowClk,
  input  logic                           slowRstN,
  input  strobe_t                        strobes,
  input  logic [DATA_W-1:0]              wrData,
  input  logic                           reqTogIn,
  output logic                           ackTog,
  output logic [NUM_REGS-1:0][DATA_W-1:0] xferData,
  output logic [NUM_REGS-1:0][DATA_W-1:0] slowRegs
);
  logic [NUM_REGS-1:0][DATA_W-1:0] shadow;
  logic [NUM_REGS-1:0]             xferMask;
  logic [1:0]                      reqSync;
  logic                            reqEdge;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) xferMask <= '0;
    else if (strobes.launch) xferMask <= strobes.launchMask;
  end

  assign reqEdge = reqSync[1] ^ ackTog;

  always_ff @(posedge slowClk or negedge slowRstN) begin
    if (!slowRstN) begin
      reqSync <= '0;
      ackTog  <= 1'b0;
    end else begin
      reqSync <= {reqSync[0], reqTogIn};
      if (reqEdge) ackTog <= reqSync[1];
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge busClk or negedge busRstN) begin
      if (!busRstN) begin
        shadow[i]   <= '0;
        xferData[i] <= '0;
      end else begin
        if (strobes.wrStrobe[i]) shadow[i] <= wrData;
        if (strobes.launch) xferData[i] <= shadow[i];
      end
    end

    always_ff @(posedge slowClk or negedge slowRstN) begin
      if (!slowRstN) slowRegs[i] <= '0;
      else if (reqEdge && xferMask[i]) slowRegs[i] <= xferData[i];
    end
  end
endmodule

// File: rtl/cdc_reg_shadow.sv
module cdc_reg_shadow
  import cdc_reg_shadow_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              slowClk,
  input  logic              slowRstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [2:0]        busy,
  output logic [DATA_W-1:0] slowCtrl,
  output logic [DATA_W-1:0] slowCmp0,
  output logic [DATA_W-1:0] slowCmp1
);
  strobe_t                         strobes;
  logic                            inFlight;
  logic                            freezeOn;
  logic                            ackTog;
  logic                            reqTog;
  logic [NUM_REGS-1:0][DATA_W-1:0] xferData;
  logic [NUM_REGS-1:0][DATA_W-1:0] slowRegs;

  cdc_reg_shadow_ctrl u_ctrl (
    .busClk   (busClk),
    .busRstN  (busRstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrBit0   (wrData[0]),
    .ackTogIn (ackTog),
    .strobes  (strobes),
    .busy     (busy),
    .inFlight (inFlight),
    .freezeOn (freezeOn)
  );

  assign reqTog = inFlight ^ u_ctrl.ackSync[1];

  cdc_reg_shadow_data #(.DATA_W(DATA_W)) u_data (
    .busClk   (busClk),
    .busRstN  (busRstN),
    .slowClk  (slowClk),
    .slowRstN (slowRstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .reqTogIn (reqTog),
    .ackTog   (ackTog),
    .xferData (xferData),
    .slowRegs (slowRegs)
  );

  assign slowCtrl = slowRegs[0];
  assign slowCmp0 = slowRegs[1];
  assign slowCmp1 = slowRegs[2];
endmodule

// File: rtl/cdc_reg_shadow_chk.sv
module cdc_reg_shadow_chk #(
  parameter int DATA_W = 24
) (
  input logic                  busClk,
  input logic                  busRstN,
  input logic                  slowClk,
  input logic                  slowRstN,
  input logic                  wrEn,
  input logic [1:0]            wrSel,
  input logic [2:0]            busy,
  input logic                  freezeOn,
  input logic                  inFlight,
  input logic                  ackTog,
  input logic [3*DATA_W-1:0]   xferFlat,
  input logic [DATA_W-1:0]     slowCtrl,
  input logic [DATA_W-1:0]     slowCmp0,
  input logic [DATA_W-1:0]     slowCmp1
);
  a_r2_busy_after_write: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrEn && wrSel != 2'd3 && !freezeOn) |=> busy[$past(wrSel)]);

  a_r4_frozen_quiet: assert property (@(posedge busClk) disable iff (!busRstN)
    (freezeOn && !inFlight) |-> (busy == 3'b000));

  a_r6_snapshot_stable: assert property (@(posedge busClk) disable iff (!busRstN)
    (inFlight && $past(inFlight)) |-> $stable(xferFlat));

  a_r7_update_with_ack: assert property (@(posedge slowClk) disable iff (!slowRstN)
    (!$stable(slowCtrl) || !$stable(slowCmp0) || !$stable(slowCmp1)) |-> !$stable(ackTog));
endmodule

bind cdc_reg_shadow cdc_reg_shadow_chk #(.DATA_W(DATA_W)) u_chk (
  .busClk   (busClk),
  .busRstN  (busRstN),
  .slowClk  (slowClk),
  .slowRstN (slowRstN),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .busy     (busy),
  .freezeOn (freezeOn),
  .inFlight (inFlight),
  .ackTog   (ackTog),
  .xferFlat (xferData),
  .slowCtrl (slowCtrl),
  .slowCmp0 (slowCmp0),
  .slowCmp1 (slowCmp1)
);

// File: tb/cdc_reg_shadow_tb.sv
module cdc_reg_shadow_tb;
  localparam int DW = 24;

  logic          busClk = 1'b0;
  logic          slowClk = 1'b0;
  logic          busRstN = 1'b0;
  logic          slowRstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrSel = 2'd0;
  logic [DW-1:0] wrData = '0;
  logic [2:0]    busy;
  logic [DW-1:0] slowCtrl, slowCmp0, slowCmp1;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] model [3];

  always #5 busClk = ~busClk;
  always #23 slowClk = ~slowClk;

  cdc_reg_shadow #(.DATA_W(DW)) u_dut (
    .busClk(busClk), .busRstN(busRstN), .slowClk(slowClk), .slowRstN(slowRstN),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .busy(busy),
    .slowCtrl(slowCtrl), .slowCmp0(slowCmp0), .slowCmp1(slowCmp1)
  );

  function automatic logic [DW-1:0] outOf(int i);
    if (i == 0) return slowCtrl;
    if (i == 1) return slowCmp0;
    return slowCmp1;
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [DW-1:0] d);
    @(negedge busClk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge busClk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle(string req);
    int n = 0;
    while (busy != 3'b000 && n < 2000) begin
      @(negedge busClk);
      n++;
    end
    check(n < 2000, req, {21'd0, busy}, '0);
  endtask

  task automatic checkModel(string req);
    for (int i = 0; i < 3; i++) check(outOf(i) == model[i], req, outOf(i), model[i]);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) model[i] = '0;
    repeat (3) @(negedge busClk);
    busRstN = 1'b1; slowRstN = 1'b1;
    @(negedge busClk);
    // R1: reset state
    check(busy == 3'b000, "R1 busy", {21'd0, busy}, '0);
    checkModel("R1 outputs");

    // R2/R3: each register, several values, others untouched
    for (int i = 0; i < 3; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [DW-1:0] v;
        v = DW'((i + 1) * 24'h13579 + k * 24'h2468A3 + 24'h5);
        wr(2'(i), v);
        check(busy == 3'(1 << i), "R2 busy rise", {21'd0, busy}, DW'(1 << i));
        waitIdle("R2 busy clears");
        model[i] = v;
        checkModel("R3 selected only");
      end
    end

    // R4/R5: freeze batch for every register subset
    for (int m = 1; m < 8; m++) begin
      logic [DW-1:0] nv [3];
      int pc, hits, n;
      wr(2'd3, 24'h000001);
      pc = 0;
      for (int i = 0; i < 3; i++) begin
        nv[i] = model[i] ^ DW'(24'h800001 + m * 24'h10101 + i * 24'h111);
        if (m[i]) begin
          wr(2'(i), nv[i]);
          pc++;
        end
      end
      repeat (300) @(negedge busClk);
      check(busy == 3'b000, "R4 busy held low", {21'd0, busy}, '0);
      checkModel("R4 outputs held");
      wr(2'd3, 24'hFFFFFE);
      check(busy == 3'(m), "R5 busy on release", {21'd0, busy}, DW'(m));
      n = 0; hits = 0;
      while (hits != pc && n < 200) begin
        @(negedge slowClk);
        hits = 0;
        for (int i = 0; i < 3; i++) if (m[i] && outOf(i) == nv[i]) hits++;
        check(hits == 0 || hits == pc, "R5 simultaneous", DW'(hits), DW'(pc));
        n++;
      end
      waitIdle("R5 busy clears");
      for (int i = 0; i < 3; i++) if (m[i]) model[i] = nv[i];
      checkModel("R5 batch values");
    end

    // R6: back-to-back writes to one register
    begin
      int n = 0;
      bit stayed = 1'b1;
      @(negedge busClk);
      wrEn = 1'b1; wrSel = 2'd1; wrData = 24'hA5A5A5;
      @(negedge busClk);
      wrData = 24'h3C3C3C;
      @(negedge busClk);
      wrEn = 1'b0;
      while (slowCmp0 != 24'h3C3C3C && n < 2000) begin
        if (!busy[1]) stayed = 1'b0;
        @(negedge busClk);
        n++;
      end
      check(stayed, "R6 busy held through relaunch", {23'd0, stayed}, 24'd1);
      waitIdle("R6 busy clears");
      model[1] = 24'h3C3C3C;
      checkModel("R6 last value wins");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog R1 actual=%h expected=%h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule